// File: doc/BRIEF.md
# Write Buffer with Watermark Drain

This block arbitrates one shared command bus between a stream of read requests and a stream of write requests. Reads pass straight through and are issued in the cycle they are offered. Writes are accepted into an internal first-in first-out store and held there, so that reads keep the bus for as long as possible. Each reversal of the bus costs a fixed number of idle cycles. The block therefore moves writes out in batches and does not interleave them with reads.

A batch is forced when the store's occupancy reaches a high watermark. The block then refuses reads, spends the turnaround penalty, and issues buffered writes one per cycle until occupancy has fallen to a low watermark. It then turns the bus back to reads. The gap between the two watermarks gives the hysteresis that keeps turnarounds rare. When no read is being offered and the store is not empty, the block also turns to writes on its own. This opportunistic batch ends as soon as a read appears or the store runs dry. Whenever the store is full and no write leaves in the same cycle, new writes are held off through the ready signal.

Top module: `write_drain_buffer`

## Requirements
- R1: While reset is asserted and in the first cycle after it is released, no command is issued, both ready outputs are 1 and busDirWrite is 0.
- R2: In read mode with occupancy below the high watermark, rdReady is 1. A valid read is issued in that same cycle with cmdValid=1, cmdIsWrite=0 and cmdAddr equal to rdAddr.
- R3: While a read is offered on every cycle and occupancy stays below the high watermark (default 12), no write is issued.
- R4: In the cycle in which occupancy equals the high watermark in read mode, reads are refused and nothing issues. The block then stays idle for TURN cycles in total (default 3), counting that cycle, and after that issues one write per cycle.
- R5: A watermark-forced batch keeps issuing writes while occupancy is above the low watermark (default 4). In the first cycle occupancy equals the low watermark, nothing issues. After TURN idle cycles in total, reads issue again.
- R6: Writes leave in the order they were accepted, each carrying the address and data it was accepted with. Every accepted write is issued exactly once.
- R7: busDirWrite is 1 on every cycle a write issues and 0 on every cycle a read issues. A command is never followed in the next cycle by a command of the opposite direction.
- R8: In read mode with no read offered and a non-empty store, the block goes idle for TURN cycles and then issues writes one per cycle until the store is empty. It then spends TURN idle cycles before it accepts a read again.
- R9: A read offered during an opportunistic batch ends the batch. No command issues in that cycle or in the following TURN-1 cycles, and the read issues in the cycle after them.
- R10: wrReady is 0 exactly when the store is full and no write issues in that cycle. Otherwise it is 1, so a write is never lost or overwritten.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| rdValid | input | 1 | A read request is offered |
| rdAddr | input | ADDR_W | Address of the offered read |
| rdReady | output | 1 | The offered read is taken and issued this cycle |
| wrValid | input | 1 | A write request is offered |
| wrAddr | input | ADDR_W | Address of the offered write |
| wrData | input | DATA_W | Data of the offered write |
| wrReady | output | 1 | The offered write is accepted into the store this cycle |
| cmdValid | output | 1 | A command is issued on the bus this cycle |
| cmdIsWrite | output | 1 | 1 for a write command, 0 for a read command |
| cmdAddr | output | ADDR_W | Address of the issued command |
| cmdData | output | DATA_W | Data of an issued write, zero for a read |
| busDirWrite | output | 1 | Bus is set toward, or in, the write direction |

## Verification
The hardest state to reach is a full store, which back-pressure has to guard. With the default sizing, the few writes that can arrive during the turnaround into a forced batch never close the gap between the high watermark and the depth. The store therefore never fills from the ports. The bench adds a second instance whose depth sits one entry above its high watermark, and it keeps offering writes through the switch to write mode. That instance fills during its turnaround, and the bench checks that wrReady drops for exactly the remaining turnaround cycles. It also checks that the held write is issued in order afterwards. A sweep over every batch size below the high watermark covers the opportunistic path at each occupancy.

// File: rtl/wbuf_pkg.sv
package wbuf_pkg;

  typedef enum logic [1:0] {
    ST_READ    = 2'd0,
    ST_TURN_WR = 2'd1,
    ST_WRITE   = 2'd2,
    ST_TURN_RD = 2'd3
  } busState_e;

  typedef struct packed {
    logic push;
    logic pop;
  } bufStrobe_t;

endpackage

// File: rtl/wbuf_store.sv
module wbuf_store
  import wbuf_pkg::*;
#(
  parameter int DEPTH  = 16,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 16,
  parameter int CNT_W  = $clog2(DEPTH + 1)
) (
  input  logic              clk,
  input  logic              rstN,
  input  bufStrobe_t        strobe,
  input  logic [ADDR_W-1:0] inAddr,
  input  logic [DATA_W-1:0] inData,
  output logic [ADDR_W-1:0] headAddr,
  output logic [DATA_W-1:0] headData,
  output logic [CNT_W-1:0]  occupancy
);

  localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int ENT_W = ADDR_W + DATA_W;
  localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(DEPTH);

  logic [ENT_W-1:0] slots [DEPTH];
  logic [PTR_W-1:0] headPtr;
  logic [PTR_W-1:0] tailPtr;

  always_ff @(posedge clk) begin
    if (strobe.push) begin
      slots[tailPtr] <= {inAddr, inData};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      headPtr   <= '0;
      tailPtr   <= '0;
      occupancy <= '0;
    end else begin
      if (strobe.push) begin
        tailPtr <= (tailPtr == LAST_PTR) ? '0 : tailPtr + 1'b1;
      end
      if (strobe.pop) begin
        headPtr <= (headPtr == LAST_PTR) ? '0 : headPtr + 1'b1;
      end
      case ({strobe.push, strobe.pop})
        2'b10:   occupancy <= occupancy + 1'b1;
        2'b01:   occupancy <= occupancy - 1'b1;
        default: occupancy <= occupancy;
      endcase
    end
  end

  assign {headAddr, headData} = slots[headPtr];

  // R10: the store never holds more than its depth
  a_r10_no_overflow: assert property (@(posedge clk) disable iff (!rstN)
    occupancy <= FULL_CNT);

  // R10: a push without a matching pop only lands on a free slot
  a_r10_push_has_room: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.push && !strobe.pop) |-> (occupancy < FULL_CNT));

  // R6: a write only leaves when one is held
  a_r6_no_underflow: assert property (@(posedge clk) disable iff (!rstN)
    strobe.pop |-> (occupancy != '0));

endmodule

// File: rtl/wbuf_ctrl.sv
module wbuf_ctrl
  import wbuf_pkg::*;
#(
  parameter int DEPTH    = 16,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 4,
  parameter int TURN     = 3,
  parameter int CNT_W    = $clog2(DEPTH + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             rdValid,
  input  logic             wrValid,
  input  logic [CNT_W-1:0] occupancy,
  output bufStrobe_t       strobe,
  output logic             rdReady,
  output logic             wrReady,
  output logic             issueRd,
  output logic             issueWr,
  output logic             busDirWrite
);

  localparam int TURN_W = (TURN > 1) ? $clog2(TURN) : 1;
  localparam logic [TURN_W-1:0] TURN_LOAD = TURN_W'(TURN - 1);
  localparam logic [CNT_W-1:0] HIGH_C = CNT_W'(HIGH_MARK);
  localparam logic [CNT_W-1:0] LOW_C  = CNT_W'(LOW_MARK);
  localparam logic [CNT_W-1:0] FULL_C = CNT_W'(DEPTH);
  localparam busState_e TO_WR = (TURN > 1) ? ST_TURN_WR : ST_WRITE;
  localparam busState_e TO_RD = (TURN > 1) ? ST_TURN_RD : ST_READ;

  busState_e         state, nextState;
  logic [TURN_W-1:0] turnCnt;
  logic              drainMode, drainNext;
  logic              loadTurn;
  logic              forcedNow;
  logic              stopWrite;

  always_comb begin
    nextState = state;
    drainNext = drainMode;
    loadTurn  = 1'b0;
    issueRd   = 1'b0;
    issueWr   = 1'b0;
    forcedNow = drainMode || (occupancy >= HIGH_C);
    stopWrite = 1'b0;
    case (state)
      ST_READ: begin
        if (occupancy >= HIGH_C) begin
          nextState = TO_WR;
          drainNext = 1'b1;
          loadTurn  = 1'b1;
        end else if (rdValid) begin
          issueRd = 1'b1;
        end else if (occupancy != '0) begin
          nextState = TO_WR;
          drainNext = 1'b0;
          loadTurn  = 1'b1;
        end
      end
      ST_TURN_WR: begin
        if (turnCnt <= 1) nextState = ST_WRITE;
      end
      ST_WRITE: begin
        drainNext = forcedNow;
        stopWrite = forcedNow ? (occupancy <= LOW_C)
                              : (rdValid || occupancy == '0);
        if (stopWrite) begin
          nextState = TO_RD;
          loadTurn  = 1'b1;
        end else begin
          issueWr = 1'b1;
        end
      end
      default: begin
        if (turnCnt <= 1) nextState = ST_READ;
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= ST_READ;
      turnCnt   <= '0;
      drainMode <= 1'b0;
    end else begin
      state     <= nextState;
      drainMode <= drainNext;
      if (loadTurn) begin
        turnCnt <= TURN_LOAD;
      end else if (turnCnt != '0) begin
        turnCnt <= turnCnt - 1'b1;
      end
    end
  end

  assign rdReady     = (state == ST_READ) && (occupancy < HIGH_C);
  assign wrReady     = (occupancy < FULL_C) || issueWr;
  assign strobe.push = wrValid && wrReady;
  assign strobe.pop  = issueWr;
  assign busDirWrite = (state == ST_TURN_WR) || (state == ST_WRITE);

  // R7: a read never directly follows a write
  a_r7_rd_after_wr_gap: assert property (@(posedge clk) disable iff (!rstN)
    issueRd |-> !$past(issueWr));

  // R7: a write never directly follows a read
  a_r7_wr_after_rd_gap: assert property (@(posedge clk) disable iff (!rstN)
    issueWr |-> !$past(issueRd));

  // R7: direction output agrees with the issued command
  a_r7_dir_matches: assert property (@(posedge clk) disable iff (!rstN)
    (issueWr |-> busDirWrite) and (issueRd |-> !busDirWrite));

  // R3: reads only issue below the high watermark
  a_r3_rd_below_high: assert property (@(posedge clk) disable iff (!rstN)
    issueRd |-> (occupancy < HIGH_C));

  // R4: reaching the high watermark in read mode leaves read mode
  a_r4_high_leaves_read: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_READ && occupancy >= HIGH_C) |=> (state != ST_READ));

  // R5: a forced batch does not stop above the low watermark
  a_r5_drain_holds: assert property (@(posedge clk) disable iff (!rstN)
    ($past(issueWr) && drainMode && state == ST_WRITE && occupancy > LOW_C)
      |-> issueWr);

endmodule

// File: rtl/write_drain_buffer.sv
module write_drain_buffer
  import wbuf_pkg::*;
#(
  parameter int DEPTH     = 16,
  parameter int HIGH_MARK = 12,
  parameter int LOW_MARK  = 4,
  parameter int TURN      = 3,
  parameter int ADDR_W    = 8,
  parameter int DATA_W    = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rdValid,
  input  logic [ADDR_W-1:0] rdAddr,
  output logic              rdReady,
  input  logic              wrValid,
  input  logic [ADDR_W-1:0] wrAddr,
  input  logic [DATA_W-1:0] wrData,
  output logic              wrReady,
  output logic              cmdValid,
  output logic              cmdIsWrite,
  output logic [ADDR_W-1:0] cmdAddr,
  output logic [DATA_W-1:0] cmdData,
  output logic              busDirWrite
);

  localparam int CNT_W = $clog2(DEPTH + 1);

  bufStrobe_t        strobe;
  logic [CNT_W-1:0]  occupancy;
  logic [ADDR_W-1:0] headAddr;
  logic [DATA_W-1:0] headData;
  logic              issueRd;
  logic              issueWr;

  wbuf_ctrl #(
    .DEPTH(DEPTH), .HIGH_MARK(HIGH_MARK), .LOW_MARK(LOW_MARK),
    .TURN(TURN), .CNT_W(CNT_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .rdValid(rdValid), .wrValid(wrValid),
    .occupancy(occupancy), .strobe(strobe), .rdReady(rdReady),
    .wrReady(wrReady), .issueRd(issueRd), .issueWr(issueWr),
    .busDirWrite(busDirWrite)
  );

  wbuf_store #(
    .DEPTH(DEPTH), .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)
  ) store_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .inAddr(wrAddr),
    .inData(wrData), .headAddr(headAddr), .headData(headData),
    .occupancy(occupancy)
  );

  assign cmdValid   = issueRd || issueWr;
  assign cmdIsWrite = issueWr;
  assign cmdAddr    = issueWr ? headAddr : rdAddr;
  assign cmdData    = issueWr ? headData : '0;

endmodule

// File: tb/write_drain_buffer_tb.sv
module write_drain_buffer_tb_top;

  localparam int CLK_P = 10;
  localparam int DEPTH = 16, HIGH = 12, LOW = 4, TURN = 3;
  localparam int S_DEPTH = 8, S_HIGH = 7, S_LOW = 2;

  logic clk = 1'b0;
  always #(CLK_P / 2) clk = ~clk;
  logic rstN;

  logic rv, wv, cv, cw, dir, rr, wr;
  logic [7:0] ra, wa, ca;
  logic [15:0] wd, cd;

  logic s_rv, s_wv, s_cv, s_cw, s_dir, s_rr, s_wr;
  logic [7:0] s_ra, s_wa, s_ca;
  logic [15:0] s_wd, s_cd;

  int checks = 0;
  int errors = 0;

  write_drain_buffer #(.DEPTH(DEPTH), .HIGH_MARK(HIGH), .LOW_MARK(LOW),
    .TURN(TURN), .ADDR_W(8), .DATA_W(16)) dut_i (
    .clk(clk), .rstN(rstN), .rdValid(rv), .rdAddr(ra), .rdReady(rr),
    .wrValid(wv), .wrAddr(wa), .wrData(wd), .wrReady(wr),
    .cmdValid(cv), .cmdIsWrite(cw), .cmdAddr(ca), .cmdData(cd),
    .busDirWrite(dir));

  write_drain_buffer #(.DEPTH(S_DEPTH), .HIGH_MARK(S_HIGH), .LOW_MARK(S_LOW),
    .TURN(TURN), .ADDR_W(8), .DATA_W(16)) dutSmall_i (
    .clk(clk), .rstN(rstN), .rdValid(s_rv), .rdAddr(s_ra), .rdReady(s_rr),
    .wrValid(s_wv), .wrAddr(s_wa), .wrData(s_wd), .wrReady(s_wr),
    .cmdValid(s_cv), .cmdIsWrite(s_cw), .cmdAddr(s_ca), .cmdData(s_cd),
    .busDirWrite(s_dir));

  function automatic logic [15:0] wdOf(input logic [7:0] a);
    return {a ^ 8'h5A, ~a};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic cyc(input logic irv, input logic [7:0] ira, input logic iwv,
                     input logic [7:0] iwa);
    @(negedge clk);
    rv = irv; ra = ira; wv = iwv; wa = iwa; wd = wdOf(iwa);
    #1;
  endtask

  task automatic cyc2(input logic irv, input logic [7:0] ira, input logic iwv,
                      input logic [7:0] iwa);
    @(negedge clk);
    s_rv = irv; s_ra = ira; s_wv = iwv; s_wa = iwa; s_wd = wdOf(iwa);
    #1;
  endtask

  task automatic expIdle(input string req, input int n, input logic irv);
    for (int c = 0; c < n; c++) begin
      cyc(irv, 8'h40 + 8'(c), 1'b0, 8'h00);
      chk(req, cv, 1'b0);
    end
  endtask

  task automatic expWrites(input string req, input int n, inout logic [7:0] expW);
    for (int c = 0; c < n; c++) begin
      cyc(1'b0, 8'h00, 1'b0, 8'h00);
      chk(req, {cv, cw}, 2'b11);
      chk("R6 addr", ca, expW);
      chk("R6 data", cd, wdOf(expW));
      chk("R7 dir on write", dir, 1'b1);
      expW = expW + 8'd1;
    end
  endtask

  task automatic summary();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(CLK_P * 150000);
    checks++;
    errors++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    logic [7:0] nextW;
    logic [7:0] expW;
    rstN = 1'b0;
    rv = 0; ra = 0; wv = 0; wa = 0; wd = 0;
    s_rv = 0; s_ra = 0; s_wv = 0; s_wa = 0; s_wd = 0;
    repeat (3) @(negedge clk);
    #1;
    chk("R1 cmd in reset", cv, 1'b0);
    chk("R1 dir in reset", dir, 1'b0);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    chk("R1 cmd", cv, 1'b0);
    chk("R1 rdReady", rr, 1'b1);
    chk("R1 wrReady", wr, 1'b1);
    chk("R1 dir", dir, 1'b0);
    chk("R1 small wrReady", s_wr, 1'b1);

    // R2: plain reads pass straight through
    for (int k = 0; k < 8; k++) begin
      cyc(1'b1, 8'h20 + 8'(k), 1'b0, 8'h00);
      chk("R2 rdReady", rr, 1'b1);
      chk("R2 issue", {cv, cw}, 2'b10);
      chk("R2 addr", ca, 8'h20 + 8'(k));
      chk("R7 dir on read", dir, 1'b0);
    end

    // R4/R5: forced batch from the high watermark down to the low one
    nextW = 8'h80;
    expW  = 8'h80;
    for (int k = 0; k < HIGH; k++) begin
      cyc(1'b1, 8'(k), 1'b1, nextW);
      chk("R3 read while buffering", {cv, cw}, 2'b10);
      chk("R10 wrReady", wr, 1'b1);
      nextW = nextW + 8'd1;
    end
    cyc(1'b1, 8'h50, 1'b0, 8'h00);
    chk("R4 reads refused", rr, 1'b0);
    chk("R4 idle", cv, 1'b0);
    expIdle("R4 turnaround idle", TURN - 1, 1'b1);
    for (int c = 0; c < HIGH - LOW; c++) begin
      cyc(1'b1, 8'h51, 1'b0, 8'h00);
      chk("R4 write issue", {cv, cw}, 2'b11);
      chk("R6 addr", ca, expW);
      chk("R6 data", cd, wdOf(expW));
      chk("R7 dir on write", dir, 1'b1);
      expW = expW + 8'd1;
    end
    expIdle("R5 stop at low mark", TURN, 1'b1);
    cyc(1'b1, 8'h33, 1'b0, 8'h00);
    chk("R5 read resumes", {cv, cw}, 2'b10);
    chk("R5 read addr", ca, 8'h33);
    chk("R7 dir on read", dir, 1'b0);

    // R8: opportunistic drain of the remaining LOW writes
    expIdle("R8 turnaround idle", TURN, 1'b0);
    expWrites("R8 write issue", LOW, expW);
    expIdle("R8 idle after empty", TURN, 1'b0);
    cyc(1'b1, 8'h34, 1'b0, 8'h00);
    chk("R8 read after batch", {cv, cw}, 2'b10);

    // R9: a read arriving mid-batch ends the batch
    for (int k = 0; k < 3; k++) begin
      cyc(1'b1, 8'(k), 1'b1, nextW);
      nextW = nextW + 8'd1;
    end
    expIdle("R8 turnaround idle", TURN, 1'b0);
    expWrites("R9 first write", 1, expW);
    expIdle("R9 idle on read arrival", TURN, 1'b1);
    cyc(1'b1, 8'h77, 1'b0, 8'h00);
    chk("R9 read issues", {cv, cw}, 2'b10);
    chk("R9 read addr", ca, 8'h77);
    expIdle("R8 turnaround idle", TURN, 1'b0);
    expWrites("R9 rest of batch", 2, expW);
    expIdle("R8 idle after empty", TURN, 1'b0);

    // R3/R8 sweep over every batch size below the high watermark
    for (int n = 1; n < HIGH; n++) begin
      for (int k = 0; k < n; k++) begin
        cyc(1'b1, 8'(k), 1'b1, nextW);
        chk("R3 read while buffering", {cv, cw}, 2'b10);
        nextW = nextW + 8'd1;
      end
      for (int k = 0; k < 4; k++) begin
        cyc(1'b1, 8'h60, 1'b0, 8'h00);
        chk("R3 no write below high", {cv, cw}, 2'b10);
      end
      expIdle("R8 turnaround idle", TURN, 1'b0);
      expWrites("R8 sweep write", n, expW);
      expIdle("R8 idle after empty", TURN, 1'b0);
    end

    // R10: small instance fills during its turnaround
    nextW = 8'h10;
    expW  = 8'h10;
    for (int k = 0; k < S_HIGH; k++) begin
      cyc2(1'b1, 8'(k), 1'b1, nextW);
      chk("R10 small wrReady", s_wr, 1'b1);
      chk("R2 small read", {s_cv, s_cw}, 2'b10);
      nextW = nextW + 8'd1;
    end
    cyc2(1'b1, 8'h00, 1'b1, nextW);
    chk("R4 small idle", s_cv, 1'b0);
    chk("R10 room before full", s_wr, 1'b1);
    nextW = nextW + 8'd1;
    // depth is one above the high mark, so the store is full for TURN-1 cycles
    for (int c = 0; c < TURN - 1; c++) begin
      cyc2(1'b1, 8'h00, 1'b1, nextW);
      chk("R10 full holds writes", s_wr, 1'b0);
      chk("R4 small idle", s_cv, 1'b0);
    end
    cyc2(1'b1, 8'h00, 1'b1, nextW);
    chk("R10 ready while popping", s_wr, 1'b1);
    chk("R4 small write", {s_cv, s_cw}, 2'b11);
    chk("R6 small addr", s_ca, expW);
    expW  = expW + 8'd1;
    nextW = nextW + 8'd1;
    // accepted S_HIGH+2 writes, batch stops at S_LOW left
    for (int c = 1; c < S_HIGH + 2 - S_LOW; c++) begin
      cyc2(1'b1, 8'h00, 1'b0, 8'h00);
      chk("R5 small write", {s_cv, s_cw}, 2'b11);
      chk("R6 small addr", s_ca, expW);
      chk("R6 small data", s_cd, wdOf(expW));
      expW = expW + 8'd1;
    end
    for (int c = 0; c < TURN; c++) begin
      cyc2(1'b1, 8'h00, 1'b0, 8'h00);
      chk("R5 small stop at low", s_cv, 1'b0);
    end
    cyc2(1'b1, 8'h99, 1'b0, 8'h00);
    chk("R5 small read resumes", {s_cv, s_cw}, 2'b10);
    chk("R5 small read addr", s_ca, 8'h99);
    for (int c = 0; c < TURN; c++) begin
      cyc2(1'b0, 8'h00, 1'b0, 8'h00);
      chk("R8 small idle", s_cv, 1'b0);
    end
    for (int c = 0; c < S_LOW; c++) begin
      cyc2(1'b0, 8'h00, 1'b0, 8'h00);
      chk("R6 small leftover", {s_cv, s_cw}, 2'b11);
      chk("R6 small leftover addr", s_ca, expW);
      expW = expW + 8'd1;
    end
    chk("R6 small all issued", expW, nextW);

    summary();
    $finish;
  end

endmodule